// File: doc/BRIEF.md
# Microprogram Sequencer with Return-Address Stack

This block is the control engine of a microcoded unit. It holds a writable control store and fetches one microword per clock into a pipeline register. That register drives the control field out of the block. It also feeds the next-address decision. A microprogram counter register keeps the address after the one just fetched. A condition multiplexer picks a test among two external conditions and the constants false and true. A small decoder then combines that test with the microword's sequencing opcode and picks the next fetch address from one of four sources: the counter, the microword branch field, an externally loaded alternate-address register, or the top of a return-address stack.

Subroutine calls push the counter value and returns pop it. The stack pointer moves up and down, so calls can nest to the configured depth. A call into a full stack or a return from an empty stack sets a sticky error flag and leaves the pointer where it was. The control store is written through a simple synchronous write port and read asynchronously by the fetch logic.

Top module: `useq_sequencer`

## Requirements
- R1: While rst_ni is low, uaddr_o, ctrl_o and stack_err_o are 0. The first microword fetched after release comes from address 0.
- R2: A microword with opcode 0 (continue) is followed by the word at its address plus one, wrapping at the top of the address space.
- R3: The condition-select field, bits [1:0], chooses the test: 0 = false, 1 = cond0_i, 2 = cond1_i, 3 = true. The condition inputs are sampled in the cycle in which the word is shown on ctrl_o/uaddr_o.
- R4: Opcode 1 (jump) with a true test is followed by the word at the branch field, bits [AW+4:5]. With a false test it continues.
- R5: Opcode 2 (call) with a true test pushes the word's address plus one and fetches from the branch field.
- R6: Opcode 3 (return) with a true test on a non-empty stack fetches from the most recently pushed address and removes it. Calls nest up to DEPTH levels.
- R7: Opcode 4 (alternate jump) with a true test fetches from the alternate-address register. That register loads sar_d_i on any clock edge with sar_ld_i high and resets to 0.
- R8: Call, return and alternate jump with a false test behave as continue and leave the stack untouched.
- R9: A true call with DEPTH entries already stacked still jumps to the branch field. It stores nothing, leaves the pointer unchanged and sets stack_err_o, which stays set until reset.
- R10: A true return on an empty stack continues to the next address, leaves the pointer unchanged and sets stack_err_o (sticky).
- R11: A write on the control-store port takes effect at the clock edge. A later fetch of that address returns the new word, while the block keeps sequencing.
- R12: Opcodes 5 to 7 behave as continue. The control field, bits [WW-1:AW+5], appears unchanged on ctrl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond0_i | input | 1 | Test input selected by code 1 |
| cond1_i | input | 1 | Test input selected by code 2 |
| sar_ld_i | input | 1 | Load enable of the alternate-address register |
| sar_d_i | input | AW | Alternate-address load value |
| ucode_we_i | input | 1 | Control-store write enable |
| ucode_waddr_i | input | AW | Control-store write address |
| ucode_wdata_i | input | CW+AW+5 | Microword to write |
| ctrl_o | output | CW | Control field of the current microword |
| uaddr_o | output | AW | Address of the current microword |
| stack_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
A microword's address and control field appear one clock edge after the cycle in which the sequencer chose that address. Its sequencing effect shows up on uaddr_o at the following edge, and a stack error it raises is visible from that same edge onward. The bench builds the expected address trace of each hand-written program step by step and queues it before releasing reset. A monitor then pops one expected entry at every falling edge, starting with the edge just after the first fetch. Each of its comparisons lines up with exactly one fetched word, including the cycle in which the control store is rewritten mid-run.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam logic [2:0] NA_CONT = 3'd0;
  localparam logic [2:0] NA_JUMP = 3'd1;
  localparam logic [2:0] NA_CALL = 3'd2;
  localparam logic [2:0] NA_RET  = 3'd3;
  localparam logic [2:0] NA_SAR  = 3'd4;

  localparam logic [1:0] CS_FALSE = 2'd0;
  localparam logic [1:0] CS_C0    = 2'd1;
  localparam logic [1:0] CS_C1    = 2'd2;
  localparam logic [1:0] CS_TRUE  = 2'd3;

  typedef enum logic [1:0] {
    SRC_UPC,
    SRC_BRANCH,
    SRC_SAR,
    SRC_STACK
  } src_e;
endpackage

// File: rtl/useq_ucode_mem.sv
module useq_ucode_mem #(
  parameter int AW = 6,
  parameter int DW = 19
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] store_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) store_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = store_q[raddr_i];
endmodule

// File: rtl/useq_next_logic.sv
module useq_next_logic
  import useq_pkg::*;
(
  input  logic [2:0] nas_i,
  input  logic [1:0] csel_i,
  input  logic       cond0_i,
  input  logic       cond1_i,
  input  logic       stk_empty_i,
  output src_e       src_o,
  output logic       push_o,
  output logic       pop_o
);
  logic test;

  always_comb begin
    unique case (csel_i)
      CS_FALSE: test = 1'b0;
      CS_C0:    test = cond0_i;
      CS_C1:    test = cond1_i;
      default:  test = 1'b1;
    endcase
  end

  always_comb begin
    src_o  = SRC_UPC;
    push_o = 1'b0;
    pop_o  = 1'b0;
    if (test) begin
      case (nas_i)
        NA_JUMP: src_o = SRC_BRANCH;
        NA_CALL: begin
          src_o  = SRC_BRANCH;
          push_o = 1'b1;
        end
        NA_RET: begin
          pop_o = 1'b1;
          if (!stk_empty_i) src_o = SRC_STACK;
        end
        NA_SAR:  src_o = SRC_SAR;
        default: src_o = SRC_UPC;
      endcase
    end
  end
endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack #(
  parameter int AW    = 6,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_data_i,
  output logic [AW-1:0] top_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] sp_q;
  logic          err_q;
  logic [AW-1:0] slot_q [DEPTH];
  logic [IW-1:0] wr_idx, rd_idx;

  assign full_o  = (sp_q == PW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign wr_idx  = IW'(sp_q);
  assign rd_idx  = IW'(sp_q - 1'b1);
  assign top_o   = slot_q[rd_idx];
  assign err_o   = err_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) slot_q[wr_idx] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (push_i) begin
        if (full_o) err_q <= 1'b1;
        else        sp_q  <= sp_q + 1'b1;
      end else if (pop_i) begin
        if (empty_o) err_q <= 1'b1;
        else         sp_q  <= sp_q - 1'b1;
      end
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> $stable(sp_q));
  p_no_underflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> $stable(sp_q));
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_push_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> (sp_q == $past(sp_q) + 1'b1));
  p_single_op_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW    = 6,
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cond0_i,
  input  logic              cond1_i,
  input  logic              sar_ld_i,
  input  logic [AW-1:0]     sar_d_i,
  input  logic              ucode_we_i,
  input  logic [AW-1:0]     ucode_waddr_i,
  input  logic [CW+AW+4:0]  ucode_wdata_i,
  output logic [CW-1:0]     ctrl_o,
  output logic [AW-1:0]     uaddr_o,
  output logic              stack_err_o
);
  localparam int WW    = CW + AW + 5;
  localparam int BR_LO = 5;
  localparam int CT_LO = AW + 5;

  logic [AW-1:0] upc_q, uaddr_q, sar_q, next_addr, stk_top, branch;
  logic [WW-1:0] pl_q, fetch_word;
  logic          vld_q, push, pop, stk_full, stk_empty;
  logic [2:0]    nas;
  logic [1:0]    csel;
  src_e          src;

  assign csel   = pl_q[1:0];
  assign nas    = pl_q[4:2];
  assign branch = pl_q[BR_LO +: AW];

  useq_next_logic i_next (
    .nas_i       (nas),
    .csel_i      (csel),
    .cond0_i     (cond0_i),
    .cond1_i     (cond1_i),
    .stk_empty_i (stk_empty),
    .src_o       (src),
    .push_o      (push),
    .pop_o       (pop)
  );

  useq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) i_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (upc_q),
    .top_o       (stk_top),
    .full_o      (stk_full),
    .empty_o     (stk_empty),
    .err_o       (stack_err_o)
  );

  always_comb begin
    unique case (src)
      SRC_BRANCH: next_addr = branch;
      SRC_SAR:    next_addr = sar_q;
      SRC_STACK:  next_addr = stk_top;
      default:    next_addr = upc_q;
    endcase
  end

  useq_ucode_mem #(.AW(AW), .DW(WW)) i_store (
    .clk_i   (clk_i),
    .we_i    (ucode_we_i),
    .waddr_i (ucode_waddr_i),
    .wdata_i (ucode_wdata_i),
    .raddr_i (next_addr),
    .rdata_o (fetch_word)
  );

  // Pipeline register holds the word at uaddr_q; upc_q already points past it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upc_q   <= '0;
      uaddr_q <= '0;
      pl_q    <= '0;
      sar_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      upc_q   <= next_addr + 1'b1;
      uaddr_q <= next_addr;
      pl_q    <= fetch_word;
      vld_q   <= 1'b1;
      if (sar_ld_i) sar_q <= sar_d_i;
    end
  end

  assign ctrl_o  = vld_q ? pl_q[CT_LO +: CW] : '0;
  assign uaddr_o = uaddr_q;

  p_first_fetch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_q) |-> (uaddr_q == '0));
  p_continue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && nas == NA_CONT) |=> (uaddr_q == $past(uaddr_q) + 1'b1));
  p_jump_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && nas == NA_JUMP && csel == CS_TRUE) |=> (uaddr_q == $past(branch)));
  p_call_saves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && nas == NA_CALL && csel == CS_TRUE && !stk_full)
      |=> (stk_top == $past(uaddr_q) + 1'b1));
  p_false_cont_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && csel == CS_FALSE) |=> (uaddr_q == $past(uaddr_q) + 1'b1));
endmodule

// File: tb/test_useq_sequencer.sv
module test_useq_sequencer;
  import useq_pkg::*;

  localparam int AW = 6;
  localparam int CW = 8;
  localparam int WW = CW + AW + 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cond0, cond1, sar_ld;
  logic [AW-1:0] sar_d;
  logic          we;
  logic [AW-1:0] waddr;
  logic [WW-1:0] wdata;
  logic [CW-1:0] ctrl;
  logic [AW-1:0] uaddr;
  logic          serr;

  int errors = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  int    q_addr[$];
  bit    q_err[$];
  string q_tag[$];

  always #5ns clk = ~clk;

  useq_sequencer #(.AW(AW), .CW(CW), .DEPTH(4)) i_useq_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .cond0_i(cond0), .cond1_i(cond1),
    .sar_ld_i(sar_ld), .sar_d_i(sar_d), .ucode_we_i(we),
    .ucode_waddr_i(waddr), .ucode_wdata_i(wdata),
    .ctrl_o(ctrl), .uaddr_o(uaddr), .stack_err_o(serr)
  );

  function automatic logic [WW-1:0] mk(int a, logic [2:0] op, logic [1:0] cs, int br);
    logic [CW-1:0] c = CW'(a + 128);
    return {c, AW'(br), op, cs};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [WW-1:0] w);
    @(negedge clk);
    we = 1'b1; waddr = AW'(a); wdata = w;
  endtask

  task automatic wr_end();
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic expect_step(int a, bit e, string tag);
    q_addr.push_back(a);
    q_err.push_back(e);
    q_tag.push_back(tag);
  endtask

  // Monitor: one expected microword per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && q_addr.size() > 0) begin
        automatic int    a = q_addr.pop_front();
        automatic bit    e = q_err.pop_front();
        automatic string t = q_tag.pop_front();
        check(uaddr == AW'(a), {t, " addr"}, uaddr, a);
        check(ctrl == CW'(a + 128), {t, " ctrl R12"}, ctrl, a + 128);
        check(serr == e, {t, " err"}, serr, e);
      end
    end
  end

  task automatic reset_check();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(uaddr == '0, "R1 reset uaddr", uaddr, 0);
    check(ctrl == '0, "R1 reset ctrl", ctrl, 0);
    check(serr == 1'b0, "R1 reset err", serr, 0);
  endtask

  task automatic run_queue();
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    mon_en = 1'b1;
  endtask

  task automatic finish_run();
    wait (q_addr.size() == 0);
    @(posedge clk);
    mon_en = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    we = 1'b0; waddr = '0; wdata = '0;
    cond0 = 1'b1; cond1 = 1'b0;
    sar_ld = 1'b1; sar_d = AW'(20);

    // Program 1: branching, nesting, conditions, underflow
    wr(0,  mk(0,  NA_CONT, CS_TRUE,  0));
    wr(1,  mk(1,  NA_JUMP, CS_FALSE, 20));
    wr(2,  mk(2,  NA_JUMP, CS_C0,    10));
    wr(10, mk(10, NA_CALL, CS_TRUE,  30));
    wr(30, mk(30, NA_CALL, CS_TRUE,  40));
    wr(40, mk(40, NA_RET,  CS_TRUE,  0));
    wr(31, mk(31, NA_RET,  CS_C1,    0));
    wr(32, mk(32, 3'd5,    CS_TRUE,  50));
    wr(33, mk(33, NA_RET,  CS_TRUE,  0));
    wr(11, mk(11, NA_SAR,  CS_TRUE,  0));
    wr(20, mk(20, NA_RET,  CS_TRUE,  0));
    wr(21, mk(21, NA_JUMP, CS_TRUE,  21));
    wr_end();
    reset_check();

    expect_step(0,  0, "R1 first fetch");
    expect_step(1,  0, "R2 continue");
    expect_step(2,  0, "R3 R8 false test continues");
    expect_step(10, 0, "R3 R4 cond0 jump");
    expect_step(30, 0, "R5 call");
    expect_step(40, 0, "R5 R6 nested call");
    expect_step(31, 0, "R6 inner return");
    expect_step(32, 0, "R3 R8 cond1 false return");
    expect_step(33, 0, "R12 reserved opcode");
    expect_step(11, 0, "R6 outer return");
    expect_step(20, 0, "R7 alternate jump");
    expect_step(21, 1, "R10 underflow continues");
    expect_step(21, 1, "R4 R10 sticky");
    expect_step(21, 1, "R10 sticky");
    run_queue();
    finish_run();

    // Program 2: overflow, alternate register reset value, live rewrite
    sar_ld = 1'b0;
    cond0 = 1'b0; cond1 = 1'b1;
    wr(0,  mk(0,  NA_CALL, CS_TRUE, 8));
    wr(8,  mk(8,  NA_CALL, CS_TRUE, 16));
    wr(16, mk(16, NA_CALL, CS_TRUE, 24));
    wr(24, mk(24, NA_CALL, CS_TRUE, 32));
    wr(32, mk(32, NA_CALL, CS_TRUE, 40));
    wr(40, mk(40, NA_JUMP, CS_C0,   0));
    wr(41, mk(41, NA_JUMP, CS_C1,   48));
    wr(48, mk(48, NA_RET,  CS_TRUE, 0));
    wr(25, mk(25, NA_RET,  CS_TRUE, 0));
    wr(17, mk(17, NA_RET,  CS_TRUE, 0));
    wr(9,  mk(9,  NA_RET,  CS_TRUE, 0));
    wr(1,  mk(1,  NA_SAR,  CS_C0,   0));
    wr(2,  mk(2,  NA_SAR,  CS_TRUE, 0));
    wr(60, mk(60, NA_JUMP, CS_TRUE, 60));
    wr_end();
    reset_check();

    expect_step(0,  0, "R1 second start");
    expect_step(8,  0, "R5 call 1");
    expect_step(16, 0, "R5 call 2");
    expect_step(24, 0, "R5 call 3");
    expect_step(32, 0, "R6 depth reached");
    expect_step(40, 1, "R9 overflow still jumps");
    expect_step(41, 1, "R3 cond0 low continues");
    expect_step(48, 1, "R3 cond1 jump");
    expect_step(25, 1, "R9 pointer unchanged");
    expect_step(17, 1, "R6 pop 3");
    expect_step(9,  1, "R6 pop 2");
    expect_step(1,  1, "R6 pop 1");
    expect_step(2,  1, "R8 false alternate jump");
    expect_step(0,  1, "R7 alternate reset value");
    expect_step(60, 1, "R11 rewritten word");
    expect_step(60, 1, "R11 loop");
    run_queue();
    repeat (2) @(negedge clk);
    we = 1'b1; waddr = '0; wdata = mk(0, NA_JUMP, CS_TRUE, 60);
    @(negedge clk);
    we = 1'b0;
    finish_run();
    summary();
  end
endmodule